// File: doc/BRIEF.md
# Halfword-Pair Write Combiner

This block sits between a 16-bit host write port and a 32-bit network transmit path. It can merge the two 16-bit halves of one 32-bit word into a single transfer. When merging is on, the first half written is kept in a small holding register. One 32-bit transfer, carrying the word's longword address and all four byte lanes, leaves only when the other half of the same word arrives. When merging is off, every host write becomes its own transfer. That transfer puts the data in the proper 16-bit lane and marks only the two byte lanes that carry it.

Some writes always pass singly, even when merging is on. These are writes made while local memory writing is disabled, and writes that carry the interrupt flag. A half that is being held is sent on alone in three cases: a write to another word arrives, the same half is written again, or merging is switched off. The transmit side is a single registered valid/ready slot. The host sees a ready signal that drops whenever its write cannot be taken in that cycle.

Top module: `hw_pair_combiner`

## Requirements
- R1: After reset, no transfer is offered (tx_valid low), nothing is held, and wr_ready is high.
- R2: With merging on, a write to one half of a longword followed by a write to the other half of the same longword yields exactly one transfer. That transfer has tx_be = 4'b1111, tx_irq low, tx_addr = host address bits [AW-1:2], and tx_data = {high half, low half}. The halves may arrive in either order.
- R3: With merging on, the first half of a pair is accepted and held, and no transfer appears until the matching half is written.
- R4: Host address bit 1 selects the half: 0 is the low half, in tx_data[15:0] with tx_be = 4'b0011; 1 is the high half, in tx_data[31:16] with tx_be = 4'b1100. The unused lane is zero. With merging off, each write produces one such single transfer.
- R5: While mem_wr_dis is high, writes are never merged or held, even with merging on.
- R6: A write with wr_irq high is never merged. It produces a single transfer with tx_irq high. Merged and flushed transfers carry tx_irq low.
- R7: While a half is held, a write to another longword, or to the same half again, first sends the held half alone as a single transfer. The write is stalled for that cycle and is then handled normally.
- R8: Clearing comb_en while a half is held sends that half alone as a single transfer, with no host write needed.
- R9: While the output slot is full and tx_ready is low, writes that need the output are not accepted (wr_ready low). A first half may still be captured when nothing is held.
- R10: A transfer leaves on a cycle with tx_valid and tx_ready both high. While tx_valid is high and tx_ready is low, all tx outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comb_en | input | 1 | Enables merging of halfword pairs |
| mem_wr_dis | input | 1 | Local memory writes disabled; forces single transfers |
| wr_en | input | 1 | Host write request |
| wr_addr | input | AW | Host byte address; bit 1 selects half, bits [AW-1:2] the longword |
| wr_data | input | 16 | Host write data |
| wr_irq | input | 1 | Write carries the interrupt flag |
| wr_ready | output | 1 | Write is taken on this cycle when high together with wr_en |
| tx_valid | output | 1 | Transfer offered |
| tx_ready | input | 1 | Transmit path accepts the transfer |
| tx_addr | output | AW-2 | Longword address of the transfer |
| tx_data | output | 32 | Transfer data |
| tx_be | output | 4 | Byte lanes carrying data |
| tx_irq | output | 1 | Transfer carries the interrupt flag |

## Verification
Merging is tried with low-then-high and high-then-low pairs to the same word, so that the lane ordering of the merged data is checked both ways. Pairs that are broken by a write to another word, or by clearing the enable, show whether the held half is sent on alone and the interrupted write is handled afterwards. Writes with merging off, with memory writes disabled, and with the interrupt flag set all show whether merging is bypassed and the lane marking is correct. A stalled transmit side shows that the output holds steady, that writes needing the output stall, and that a first half is still captured.

// File: rtl/hw_pair_combiner.sv
module hw_pair_combiner #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          comb_en,
  input  logic          mem_wr_dis,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          wr_irq,
  output logic          wr_ready,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [AW-3:0] tx_addr,
  output logic [31:0]   tx_data,
  output logic [3:0]    tx_be,
  output logic          tx_irq
);
  localparam int LW = AW - 2;

  logic          hold_vld;
  logic          hold_hi;
  logic [LW-1:0] hold_lw;
  logic [15:0]   hold_data;

  wire [LW-1:0] wr_lw     = wr_addr[AW-1:2];
  wire          wr_hi     = wr_addr[1];
  wire          slot_free = !tx_valid || tx_ready;
  wire          cmb       = comb_en && !mem_wr_dis && !wr_irq;
  wire          match     = hold_vld && cmb && (hold_lw == wr_lw) && (hold_hi != wr_hi);
  wire          flush     = hold_vld && (!comb_en || (wr_en && !match));
  wire          capture   = wr_en && cmb && !hold_vld;
  wire          emit      = slot_free && (flush || (wr_en && !capture));

  assign wr_ready = !flush && (capture || slot_free);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid  <= 1'b0;
      tx_addr   <= '0;
      tx_data   <= '0;
      tx_be     <= '0;
      tx_irq    <= 1'b0;
      hold_vld  <= 1'b0;
      hold_hi   <= 1'b0;
      hold_lw   <= '0;
      hold_data <= '0;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (emit) begin
        tx_valid <= 1'b1;
        if (flush) begin
          tx_addr  <= hold_lw;
          tx_data  <= hold_hi ? {hold_data, 16'h0} : {16'h0, hold_data};
          tx_be    <= hold_hi ? 4'b1100 : 4'b0011;
          tx_irq   <= 1'b0;
          hold_vld <= 1'b0;
        end else if (match) begin
          tx_addr  <= wr_lw;
          tx_data  <= hold_hi ? {hold_data, wr_data} : {wr_data, hold_data};
          tx_be    <= 4'b1111;
          tx_irq   <= 1'b0;
          hold_vld <= 1'b0;
        end else begin
          tx_addr  <= wr_lw;
          tx_data  <= wr_hi ? {wr_data, 16'h0} : {16'h0, wr_data};
          tx_be    <= wr_hi ? 4'b1100 : 4'b0011;
          tx_irq   <= wr_irq;
        end
      end
      if (capture) begin
        hold_vld  <= 1'b1;
        hold_hi   <= wr_hi;
        hold_lw   <= wr_lw;
        hold_data <= wr_data;
      end
    end
  end
endmodule

module hw_pair_combiner_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          comb_en,
  input logic          mem_wr_dis,
  input logic          wr_en,
  input logic          wr_irq,
  input logic          wr_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [AW-3:0] tx_addr,
  input logic [31:0]   tx_data,
  input logic [3:0]    tx_be,
  input logic          tx_irq,
  input logic          hold_vld
);
  // R10
  tx_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_be)
                              && $stable(tx_addr) && $stable(tx_irq));
  // R2
  merged_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_be == 4'b1111 |-> !tx_irq);
  // R4
  lane_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_be == 4'b0011 || tx_be == 4'b1100 || tx_be == 4'b1111));
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_ready && wr_irq |=> tx_valid && tx_irq && tx_be != 4'b1111);
  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_irq || !comb_en || mem_wr_dis) && tx_valid && !tx_ready |-> !wr_ready);
  // R8
  drop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld && !comb_en && (!tx_valid || tx_ready) |=> tx_valid && tx_be != 4'b1111 && !hold_vld);
  // R3
  first_half_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_ready && comb_en && !mem_wr_dis && !wr_irq && !hold_vld |=> hold_vld);
endmodule

bind hw_pair_combiner hw_pair_combiner_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .comb_en(comb_en), .mem_wr_dis(mem_wr_dis),
  .wr_en(wr_en), .wr_irq(wr_irq), .wr_ready(wr_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_data(tx_data), .tx_be(tx_be),
  .tx_irq(tx_irq), .hold_vld(hold_vld)
);

// File: tb/hw_pair_combiner_bench.sv
module hw_pair_combiner_bench;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic comb_en = 1'b0, mem_wr_dis = 1'b0, wr_en = 1'b0, wr_irq = 1'b0, tx_ready = 1'b1;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic wr_ready, tx_valid, tx_irq;
  logic [AW-3:0] tx_addr;
  logic [31:0] tx_data;
  logic [3:0] tx_be;

  hw_pair_combiner #(.AW(AW)) u_hw_pair_combiner (
    .clk(clk), .rst_n(rst_n), .comb_en(comb_en), .mem_wr_dis(mem_wr_dis),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_irq(wr_irq),
    .wr_ready(wr_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_addr(tx_addr), .tx_data(tx_data), .tx_be(tx_be), .tx_irq(tx_irq));

  always #5 clk = ~clk;

  typedef struct { int lw; logic [31:0] d; logic [3:0] be; logic irq; } xfer_t;
  xfer_t exp_q[$];
  xfer_t last_got;
  int got_n = 0, n_tests = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";
  bit h_vld = 0, h_hi = 0;
  int h_lw = 0;
  logic [15:0] h_d = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic xfer_t single(input int lw, input bit hi, input logic [15:0] d, input logic irq);
    xfer_t x;
    x.lw = lw; x.irq = irq;
    x.d = hi ? {d, 16'h0} : {16'h0, d};
    x.be = hi ? 4'b1100 : 4'b0011;
    return x;
  endfunction

  // Reference model, evaluated 2 ns before each rising edge
  always @(negedge clk) begin
    #3;
    cycles++;
    if (!rst_n) begin
      exp_q.delete(); h_vld = 0;
    end else begin
      bit free, cmb, pair, fl, cap, exp_rdy;
      int lw;
      bit hi;
      xfer_t x;
      lw = int'(wr_addr[AW-1:2]); hi = wr_addr[1];
      free = (exp_q.size() == 0) || tx_ready;
      cmb = comb_en && !mem_wr_dis && !wr_irq;
      pair = h_vld && cmb && h_lw == lw && h_hi != hi;
      fl = h_vld && (!comb_en || (wr_en && !pair));
      cap = wr_en && cmb && !h_vld;
      exp_rdy = !fl && (cap || free);
      chk(wr_ready == exp_rdy, cur_req, wr_ready, exp_rdy);
      chk(tx_valid == (exp_q.size() != 0), cur_req, tx_valid, exp_q.size());
      if (tx_valid && exp_q.size() != 0) begin
        chk(tx_data == exp_q[0].d && tx_be == exp_q[0].be && int'(tx_addr) == exp_q[0].lw
            && tx_irq == exp_q[0].irq, cur_req, {tx_irq, tx_be, tx_addr, tx_data},
            {exp_q[0].irq, exp_q[0].be, exp_q[0].lw[AW-3:0], exp_q[0].d});
        if (tx_ready) begin got_n++; last_got = exp_q[0]; void'(exp_q.pop_front()); end
      end
      if (fl) begin
        if (free) begin exp_q.push_back(single(h_lw, h_hi, h_d, 1'b0)); h_vld = 0; end
      end else if (cap) begin
        h_vld = 1; h_hi = hi; h_lw = lw; h_d = wr_data;
      end else if (wr_en && free) begin
        if (pair) begin
          x.lw = lw; x.be = 4'b1111; x.irq = 1'b0;
          x.d = h_hi ? {h_d, wr_data} : {wr_data, h_d};
          exp_q.push_back(x); h_vld = 0;
        end else exp_q.push_back(single(lw, hi, wr_data, wr_irq));
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic irq);
    bit acc;
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d; wr_irq = irq;
    do begin
      @(negedge clk); #4; acc = wr_ready;
      @(posedge clk); #1;
    end while (!acc);
    wr_en = 0; wr_irq = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int base;
    idle(3);
    rst_n = 1;
    @(negedge clk); #4;
    chk(!tx_valid && wr_ready, "R1", {tx_valid, wr_ready}, 2'b01);

    cur_req = "R3"; comb_en = 1; base = got_n;
    wr(16'h0100, 16'hAAAA, 0); idle(4);
    chk(got_n == base, "R3", got_n - base, 0);
    cur_req = "R2";
    wr(16'h0102, 16'hBBBB, 0); idle(3);
    chk(got_n == base + 1 && last_got.d == 32'hBBBBAAAA && last_got.be == 4'hF && last_got.lw == 'h40,
        "R2", last_got.d, 32'hBBBBAAAA);

    base = got_n;
    wr(16'h0206, 16'h1234, 0); wr(16'h0204, 16'h5678, 0); idle(3);
    chk(got_n == base + 1 && last_got.d == 32'h12345678, "R2", last_got.d, 32'h12345678);

    cur_req = "R4"; comb_en = 0; base = got_n;
    wr(16'h0010, 16'h00C3, 0); idle(2);
    chk(last_got.d == 32'h000000C3 && last_got.be == 4'b0011, "R4", last_got.be, 4'b0011);
    wr(16'h0012, 16'h00D4, 0); idle(2);
    chk(got_n == base + 2 && last_got.d == 32'h00D40000 && last_got.be == 4'b1100, "R4", last_got.d, 32'h00D40000);

    cur_req = "R5"; comb_en = 1; mem_wr_dis = 1; base = got_n;
    wr(16'h0020, 16'h1111, 0); wr(16'h0022, 16'h2222, 0); idle(2);
    chk(got_n == base + 2 && last_got.be == 4'b1100, "R5", got_n - base, 2);
    mem_wr_dis = 0;

    cur_req = "R6"; base = got_n;
    wr(16'h0030, 16'h3333, 1); idle(2);
    chk(got_n == base + 1 && last_got.irq && last_got.be == 4'b0011, "R6", last_got.irq, 1);

    cur_req = "R7"; base = got_n;
    wr(16'h0200, 16'h7000, 0); wr(16'h0300, 16'h7001, 0); idle(2);
    chk(got_n == base + 1 && last_got.lw == 'h80 && last_got.be == 4'b0011, "R7", last_got.lw, 'h80);
    wr(16'h0302, 16'h7002, 0); idle(2);
    chk(got_n == base + 2 && last_got.d == 32'h70027001, "R7", last_got.d, 32'h70027001);
    wr(16'h0402, 16'h7100, 0); wr(16'h0402, 16'h7101, 0); idle(2);
    chk(got_n == base + 3 && last_got.d == 32'h71000000, "R7", last_got.d, 32'h71000000);
    comb_en = 0; idle(2); comb_en = 1;

    cur_req = "R8"; base = got_n;
    wr(16'h0040, 16'h8888, 0); idle(2);
    comb_en = 0; idle(3);
    chk(got_n == base + 1 && last_got.lw == 'h10 && last_got.d == 32'h00008888, "R8", last_got.d, 32'h8888);

    cur_req = "R9"; base = got_n; tx_ready = 0;
    wr(16'h0050, 16'h0001, 0);
    comb_en = 1;
    wr(16'h0060, 16'h0002, 0);
    wr_en = 1; wr_addr = 16'h0062; wr_data = 16'h0003;
    idle(4);
    @(negedge clk); #4;
    chk(!wr_ready, "R9", wr_ready, 0);
    chk(tx_valid && tx_data == 32'h1 && tx_be == 4'b0011, "R10", tx_data, 32'h1);
    @(posedge clk); #1; tx_ready = 1;
    begin
      bit acc;
      do begin @(negedge clk); #4; acc = wr_ready; @(posedge clk); #1; end while (!acc);
    end
    wr_en = 0; idle(3);
    chk(got_n == base + 2 && last_got.d == 32'h00030002, "R10", last_got.d, 32'h00030002);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<5000", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule